// File: doc/BRIEF.md
# Single-Cycle Paged 8-bit Processor Core

This block is an 8-bit processor core that fetches, decodes, executes and writes back each instruction within one clock cycle. It has no microcode sequencer. Program memory and data memory are separate. Every 16-bit program word is split into an opcode byte and an immediate byte, and both are consumed in the same cycle. A 16-bit program counter drives the program memory address.

A page register, loaded by its own instruction, always supplies the high byte of every data address and of every jump target. The operand byte of the current instruction supplies the low byte. The ALU is built from two cascaded 4-bit slices. Its slice equality outputs set the equal flag, and its final carry sets the greater flag.

An 8-bit output port holds the last value written by one of the two output instructions. Software uses it to drive video sync and colour pins directly.

Top module: `paged_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, accumulator, page register, both flags and the output port to zero. The first fetch after reset is from address 0x0000.
- R2: Opcode encoding and word layout are fixed:
  - `imem_data[15:8]` is the opcode and `imem_data[7:0]` is the operand.
  - Opcodes: 0x00 NOP, 0x01 load A immediate, 0x02 load page immediate, 0x03 load A from memory, 0x04 store A, 0x05 ADD, 0x06 SUB, 0x07 AND, 0x08 OR, 0x09 XOR, 0x0A CMP, 0x0B JMP, 0x0C jump-if-equal, 0x0D jump-if-greater, 0x0E output A, 0x0F output immediate.
  - Each instruction takes one cycle, and the PC advances by one whenever no jump is taken.
- R3: A taken jump loads the PC with {page, operand}. JMP always jumps, jump-if-equal jumps when the equal flag is 1, and jump-if-greater jumps when the greater flag is 1. An untaken branch also takes one cycle and advances the PC by one.
- R4: Load A immediate writes the operand into A. Load page immediate writes the operand into the page register.
- R5: Data address handling:
  - `dmem_addr` is {page, operand}.
  - A store asserts `dmem_we` with `dmem_wdata` = A.
  - A memory load writes `dmem_rdata` into A at the end of the same cycle.
- R6: ADD, SUB, AND, OR and XOR combine A with the operand and write the result back to A, modulo 256.
- R7: Flags are written only by ADD, SUB and CMP, and keep their value across all other opcodes.
  - The equal flag becomes (A == operand).
  - The greater flag becomes the final ALU carry: unsigned overflow for ADD, A >= operand for SUB, and A > operand for CMP (CMP evaluates A - operand - 1).
- R8: CMP never changes A.
- R9: Output port behaviour:
  - Output-A copies A to `vout`, and output-immediate copies the operand to `vout`.
  - `vout` holds its value on every other opcode.
  - Bit 7 is vertical sync, bit 6 is horizontal sync, and bits 5:0 are colour (R1 R0 G1 G0 B1 B0).
- R10: Opcodes 0x10 to 0xFF behave as NOP. They leave A, the page register, the flags and the port unchanged and advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Program memory address (PC) |
| imem_data | input | 16 | Program word: opcode high byte, operand low byte |
| dmem_addr | output | 16 | Data memory address {page, operand} |
| dmem_wdata | output | 8 | Store data (A) |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 8 | Load data, combinational from data memory |
| vout | output | 8 | Output port: vsync, hsync, 6-bit colour |

## Verification
The hardest situation to reach from the ports is the flag persistence rule. A conditional jump must act on flags set several instructions earlier, with logic operations, loads and stores in between. The stimulus therefore places an AND between a CMP that sets the equal flag and the jump-if-equal that consumes it. It then proves the jump was still taken by the PC value that appears next. The three meanings of the greater flag are separated by ADD overflow, SUB with no borrow, and CMP on equal and on larger values. A mid-run reset is followed by output and branch instructions that reveal the cleared A, page and flags.

// File: rtl/pcore_pkg.sv
package pcore_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int SLICE_W = 4;
    localparam int N_SLICE = DATA_W / SLICE_W;

    typedef enum logic [7:0] {
        OP_NOP  = 8'h00, OP_LDAI = 8'h01, OP_LDYI = 8'h02, OP_LDAM = 8'h03,
        OP_STA  = 8'h04, OP_ADD  = 8'h05, OP_SUB  = 8'h06, OP_AND  = 8'h07,
        OP_OR   = 8'h08, OP_XOR  = 8'h09, OP_CMP  = 8'h0A, OP_JMP  = 8'h0B,
        OP_JEQ  = 8'h0C, OP_JGT  = 8'h0D, OP_OUTA = 8'h0E, OP_OUTI = 8'h0F
    } opcode_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_CMP, ALU_AND, ALU_OR, ALU_XOR
    } alu_op_e;

    typedef enum logic [1:0] { ASRC_KEEP, ASRC_IMM, ASRC_MEM, ASRC_ALU } asrc_e;
    typedef enum logic [1:0] { OSRC_KEEP, OSRC_ACC, OSRC_IMM } osrc_e;
    typedef enum logic [1:0] { BR_NONE, BR_ALWAYS, BR_EQ, BR_GT } br_e;

    typedef struct packed {
        asrc_e   a_src;
        logic    ld_page;
        alu_op_e alu_op;
        logic    flag_wr;
        logic    mem_we;
        osrc_e   o_src;
        br_e     br;
    } ctrl_t;

    // carry-in of the low slice; CMP uses A + ~B so that carry means A > B
    function automatic logic alu_cin(input alu_op_e op);
        return (op == ALU_SUB);
    endfunction

    function automatic logic alu_invert_b(input alu_op_e op);
        return (op == ALU_SUB) || (op == ALU_CMP);
    endfunction
endpackage

// File: rtl/pcore_slice.sv
module pcore_slice
    import pcore_pkg::*;
(
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               cin,
    input  alu_op_e            op,
    output logic [SLICE_W-1:0] f,
    output logic               cout,
    output logic               eq
);
    logic [SLICE_W-1:0] b_eff;
    logic [SLICE_W:0]   sum;

    always_comb begin
        b_eff = alu_invert_b(op) ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{SLICE_W{1'b0}}, cin};
        unique case (op)
            ALU_AND: f = a & b;
            ALU_OR:  f = a | b;
            ALU_XOR: f = a ^ b;
            default: f = sum[SLICE_W-1:0];
        endcase
        cout = sum[SLICE_W];
        eq   = (a == b);
    end
endmodule

// File: rtl/pcore_alu.sv
module pcore_alu
    import pcore_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] f,
    output logic              carry,
    output logic              equal
);
    logic [N_SLICE:0]   c_chain;
    logic [N_SLICE-1:0] eq_sl;

    assign c_chain[0] = alu_cin(op);

    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        pcore_slice u_slice (
            .a    (a[s*SLICE_W +: SLICE_W]),
            .b    (b[s*SLICE_W +: SLICE_W]),
            .cin  (c_chain[s]),
            .op   (op),
            .f    (f[s*SLICE_W +: SLICE_W]),
            .cout (c_chain[s+1]),
            .eq   (eq_sl[s])
        );
    end

    assign carry = c_chain[N_SLICE];
    assign equal = &eq_sl;
endmodule

// File: rtl/pcore_decode.sv
module pcore_decode
    import pcore_pkg::*;
(
    input  logic [7:0] opcode,
    output ctrl_t      ctl
);
    always_comb begin
        ctl = '{a_src: ASRC_KEEP, ld_page: 1'b0, alu_op: ALU_ADD, flag_wr: 1'b0,
                mem_we: 1'b0, o_src: OSRC_KEEP, br: BR_NONE};
        case (opcode)
            OP_LDAI: ctl.a_src = ASRC_IMM;
            OP_LDYI: ctl.ld_page = 1'b1;
            OP_LDAM: ctl.a_src = ASRC_MEM;
            OP_STA:  ctl.mem_we = 1'b1;
            OP_ADD:  begin ctl.a_src = ASRC_ALU; ctl.alu_op = ALU_ADD; ctl.flag_wr = 1'b1; end
            OP_SUB:  begin ctl.a_src = ASRC_ALU; ctl.alu_op = ALU_SUB; ctl.flag_wr = 1'b1; end
            OP_AND:  begin ctl.a_src = ASRC_ALU; ctl.alu_op = ALU_AND; end
            OP_OR:   begin ctl.a_src = ASRC_ALU; ctl.alu_op = ALU_OR;  end
            OP_XOR:  begin ctl.a_src = ASRC_ALU; ctl.alu_op = ALU_XOR; end
            OP_CMP:  begin ctl.alu_op = ALU_CMP; ctl.flag_wr = 1'b1; end
            OP_JMP:  ctl.br = BR_ALWAYS;
            OP_JEQ:  ctl.br = BR_EQ;
            OP_JGT:  ctl.br = BR_GT;
            OP_OUTA: ctl.o_src = OSRC_ACC;
            OP_OUTI: ctl.o_src = OSRC_IMM;
            default: ;
        endcase
    end
endmodule

// File: rtl/paged_core.sv
module paged_core
    import pcore_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [15:0]       imem_data,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic [DATA_W-1:0] dmem_wdata,
    output logic              dmem_we,
    input  logic [DATA_W-1:0] dmem_rdata,
    output logic [DATA_W-1:0] vout
);
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] acc, page, port_q, imm, alu_f;
    logic              f_eq, f_gt, alu_c, alu_eq, taken;
    logic [7:0]        opcode;
    ctrl_t             ctl;

    assign opcode = imem_data[15:8];
    assign imm    = imem_data[7:0];

    pcore_decode u_dec (.opcode(opcode), .ctl(ctl));

    pcore_alu u_alu (
        .a(acc), .b(imm), .op(ctl.alu_op),
        .f(alu_f), .carry(alu_c), .equal(alu_eq)
    );

    always_comb begin
        unique case (ctl.br)
            BR_ALWAYS: taken = 1'b1;
            BR_EQ:     taken = f_eq;
            BR_GT:     taken = f_gt;
            default:   taken = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            acc    <= '0;
            page   <= '0;
            f_eq   <= 1'b0;
            f_gt   <= 1'b0;
            port_q <= '0;
        end else begin
            pc <= taken ? {page, imm} : pc + 16'd1;
            unique case (ctl.a_src)
                ASRC_IMM: acc <= imm;
                ASRC_MEM: acc <= dmem_rdata;
                ASRC_ALU: acc <= alu_f;
                default:  ;
            endcase
            if (ctl.ld_page) page <= imm;
            if (ctl.flag_wr) begin
                f_eq <= alu_eq;
                f_gt <= alu_c;
            end
            unique case (ctl.o_src)
                OSRC_ACC: port_q <= acc;
                OSRC_IMM: port_q <= imm;
                default:  ;
            endcase
        end
    end

    assign imem_addr  = pc;
    assign dmem_addr  = {page, imm};
    assign dmem_wdata = acc;
    assign dmem_we    = ctl.mem_we;
    assign vout       = port_q;

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(taken)) |-> pc == $past(pc) + 16'd1);

    // R3
    jump_target_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(taken)) |-> pc == {$past(page), $past(imem_data[7:0])});

    // R8
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode) == OP_CMP) |-> $stable(acc));

    // R7
    cmp_eq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode) == OP_CMP) |-> f_eq == ($past(acc) == $past(imem_data[7:0])));

    // R7
    cmp_gt_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode) == OP_CMP) |-> f_gt == ($past(acc) > $past(imem_data[7:0])));

    // R9
    port_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode) != OP_OUTA && $past(opcode) != OP_OUTI) |-> $stable(vout));

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(opcode) != OP_LDYI) |-> $stable(page));
endmodule

// File: tb/paged_core_tb.sv
module paged_core_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] imem_addr, imem_data, dmem_addr;
    logic [7:0]  dmem_wdata, dmem_rdata, vout;
    logic        dmem_we;
    logic [7:0]  dmem [0:255];
    logic [15:0] last_wr_addr;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    paged_core u_dut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .vout(vout)
    );

    assign dmem_rdata = dmem[dmem_addr[7:0]];
    always @(posedge clk) if (dmem_we) begin
        dmem[dmem_addr[7:0]] <= dmem_wdata;
        last_wr_addr         <= dmem_addr;
    end

    // {expected pc at fetch, program word, expected vout after the edge}
    localparam int NROW = 33;
    localparam logic [39:0] PROG [0:NROW-1] = '{
        {16'h0000, 16'h0FC5, 8'hC5},  // R9 output immediate
        {16'h0001, 16'h013C, 8'hC5},  // R4 load A
        {16'h0002, 16'h0E00, 8'h3C},  // R9 output A
        {16'h0003, 16'h0510, 8'h3C},  // R6 add -> 4C
        {16'h0004, 16'h0E00, 8'h4C},
        {16'h0005, 16'h060C, 8'h4C},  // R6 sub -> 40, gt=1
        {16'h0006, 16'h0D20, 8'h4C},  // R3 jgt taken, page 0
        {16'h0020, 16'h0204, 8'h4C},  // R4 page = 04
        {16'h0021, 16'h0B20, 8'h4C},  // R3 jmp 0420
        {16'h0420, 16'h0A40, 8'h4C},  // R7 cmp equal
        {16'h0421, 16'h0D00, 8'h4C},  // R3 jgt untaken
        {16'h0422, 16'h0C30, 8'h4C},  // R3 jeq taken
        {16'h0430, 16'h0E00, 8'h40},  // R8 A kept by cmp
        {16'h0431, 16'h0455, 8'h40},  // R5 store
        {16'h0432, 16'h070F, 8'h40},  // R6 and -> 00
        {16'h0433, 16'h0C50, 8'h40},  // R7 eq survives AND
        {16'h0450, 16'h0355, 8'h40},  // R5 load from memory
        {16'h0451, 16'h09FF, 8'h40},  // R6 xor -> BF
        {16'h0452, 16'h0840, 8'h40},  // R6 or -> FF
        {16'h0453, 16'h0E00, 8'hFF},
        {16'h0454, 16'h0501, 8'hFF},  // R7 add overflow gt=1 eq=0
        {16'h0455, 16'h0C00, 8'hFF},
        {16'h0456, 16'h0D60, 8'hFF},
        {16'h0460, 16'h1300, 8'hFF},  // R10 unused opcode
        {16'h0461, 16'h0E00, 8'h00},
        {16'h0462, 16'h0A00, 8'h00},  // R7 cmp equal gt=0
        {16'h0463, 16'h0D70, 8'h00},
        {16'h0464, 16'h0F80, 8'h80},
        {16'h0465, 16'h0150, 8'h80},
        {16'h0466, 16'h0A4F, 8'h80},  // R7 cmp greater
        {16'h0467, 16'h0D10, 8'h80},
        {16'h0410, 16'h0000, 8'h80},  // R2 nop
        {16'h0411, 16'h0E00, 8'h50}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] word);
        imem_data = word;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
        rst = 1'b1;
        imem_data = 16'h0000;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pc", imem_addr, 16'h0000);
        chk("R1 reset vout", {8'h00, vout}, 16'h0000);
        rst = 1'b0;

        for (int r = 0; r < NROW; r++) begin
            imem_data = PROG[r][23:8];
            #1;
            chk("R2/R3 fetch pc", imem_addr, PROG[r][39:24]);
            if (PROG[r][23:16] == 8'h04) begin
                chk("R5 store addr", dmem_addr, 16'h0455);
                chk("R5 store data", {8'h00, dmem_wdata}, 16'h0040);
                chk("R5 store strobe", {15'd0, dmem_we}, 16'h0001);
            end
            @(posedge clk);
            @(negedge clk);
            chk("R9 port value", {8'h00, vout}, {8'h00, PROG[r][7:0]});
        end
        chk("R5 memory content", {8'h00, dmem[8'h55]}, 16'h0040);
        chk("R5 write address", last_wr_addr, 16'h0455);

        // mid-run reset: A was 50, page 04, gt flag 1
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pc after reset", imem_addr, 16'h0000);
        chk("R1 vout after reset", {8'h00, vout}, 16'h0000);
        step(16'h0F3F);
        chk("R9 vout imm", {8'h00, vout}, 16'h003F);
        step(16'h0E00);
        chk("R1 A cleared", {8'h00, vout}, 16'h0000);
        step(16'h0D09);
        chk("R1 gt flag cleared", imem_addr, 16'h0003);
        step(16'h0C09);
        chk("R1 eq flag cleared", imem_addr, 16'h0004);
        step(16'h0B07);
        chk("R1 page cleared", imem_addr, 16'h0007);
        step(16'hFF12);
        chk("R10 opcode FF pc", imem_addr, 16'h0008);
        chk("R10 opcode FF port", {8'h00, vout}, 16'h0000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule